// File: doc/BRIEF.md
# Selectable Input Capture Cell

This block sits between a group of input pads and the routing fabric of a programmable-logic device. It stores each pad value in one of two ways, chosen at run time by a mode bit. It can act as an edge-triggered register or as a level-sensitive transparent latch. Two global clock/enable pins are shared by the whole device. A select bit picks which one drives the cell, and a polarity bit picks which phase of that pin counts as active.

The storage has no reset and no preset, so its contents are undefined until the first capture event. The unregistered pad value is always passed through on its own output, next to the captured value. A design that wants a purely combinational input ignores the captured output and uses only the pass-through path.

Top module: `inp_capture_cell`

## Requirements
- R1: With `clk_sel_i` = 0 the cell is clocked or enabled only by `gclk0_i`, and with `clk_sel_i` = 1 only by `gclk1_i`. Toggling the pin that is not selected leaves `cap_o` unchanged.
- R2: With `mode_i` = 0 (register), `cap_o` takes the value of `pad_i` at each rising edge of the effective clock. Between such edges, `cap_o` does not follow `pad_i`.
- R3: With `clk_inv_i` = 0 the effective clock/enable equals the selected pin. With `clk_inv_i` = 1 it is the inverse of the selected pin, so in register mode capture happens on the falling pin edge.
- R4: With `mode_i` = 1 (latch), `cap_o` follows `pad_i` while the effective enable is high.
- R5: In latch mode, while the effective enable is low, `cap_o` holds the value `pad_i` had when the enable fell, and it ignores later pad changes.
- R6: `raw_o` equals `pad_i` at all times, whatever the mode, select and polarity settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pad_i | input | WIDTH | Pad values to be captured |
| gclk0_i | input | 1 | Global clock/enable pin 0 |
| gclk1_i | input | 1 | Global clock/enable pin 1 |
| clk_sel_i | input | 1 | 0 selects gclk0_i, 1 selects gclk1_i |
| clk_inv_i | input | 1 | 1 inverts the selected pin |
| mode_i | input | 1 | 0 register, 1 transparent latch |
| raw_o | output | WIDTH | Direct pad feedback |
| cap_o | output | WIDTH | Captured register or latch value |

## Verification
The hardest case to reach is a latch whose output must be seen to follow the pad, rather than a latch that only happens to hold a matching value. The stimulus opens the enable, changes the pad to its complement while the enable stays high, and only then closes the enable. It then changes the pad a third time, which tells transparency, capture-at-close and hold apart. This sequence, together with pulses on the unselected pin, is swept over every pad value and every select/polarity/mode combination.

// File: rtl/inp_cell_pkg.sv
package inp_cell_pkg;
   typedef enum logic {
      CAP_REG   = 1'b0,
      CAP_LATCH = 1'b1
   } cap_mode_e;
endpackage

// File: rtl/inp_clk_sel.sv
module inp_clk_sel (
   input  logic gclk0_i,
   input  logic gclk1_i,
   input  logic sel_i,
   input  logic inv_i,
   output logic eff_o
);
   logic picked;

   always_comb begin
      picked = sel_i ? gclk1_i : gclk0_i;
      eff_o  = picked ^ inv_i;
   end
endmodule

// File: rtl/inp_cap_reg.sv
module inp_cap_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("inp_cap_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk_i) begin
      q_o <= d_i;
   end

   // R2: each stored value is the pad sampled at the previous active edge
   a_r2_reg_captures: assert property (@(posedge clk_i)
      1'b1 |=> (q_o == $past(d_i)));
endmodule

// File: rtl/inp_cap_latch.sv
module inp_cap_latch #(
   parameter int WIDTH = 8
) (
   input  logic             en_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("inp_cap_latch: WIDTH must be at least 1");
   end

   always_latch begin
      if (en_i) q_o <= d_i;
   end

   // R5: just before the enable closes, the latch is carrying the input
   a_r5_latch_closes: assert property (@(negedge en_i)
      1'b1 |-> (q_o == d_i));
endmodule

// File: rtl/inp_capture_cell.sv
module inp_capture_cell #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] pad_i,
   input  logic             gclk0_i,
   input  logic             gclk1_i,
   input  logic             clk_sel_i,
   input  logic             clk_inv_i,
   input  logic             mode_i,
   output logic [WIDTH-1:0] raw_o,
   output logic [WIDTH-1:0] cap_o
);
   import inp_cell_pkg::*;

   if (WIDTH < 1) begin : g_bad_width
      $error("inp_capture_cell: WIDTH must be at least 1");
   end

   logic             eff;
   logic [WIDTH-1:0] reg_q;
   logic [WIDTH-1:0] lat_q;
   cap_mode_e        mode;

   assign mode  = cap_mode_e'(mode_i);
   assign raw_o = pad_i;

   inp_clk_sel u_sel (
      .gclk0_i (gclk0_i),
      .gclk1_i (gclk1_i),
      .sel_i   (clk_sel_i),
      .inv_i   (clk_inv_i),
      .eff_o   (eff)
   );

   inp_cap_reg #(.WIDTH(WIDTH)) u_reg (
      .clk_i (eff),
      .d_i   (pad_i),
      .q_o   (reg_q)
   );

   inp_cap_latch #(.WIDTH(WIDTH)) u_lat (
      .en_i (eff),
      .d_i  (pad_i),
      .q_o  (lat_q)
   );

   always_comb begin
      cap_o = (mode == CAP_LATCH) ? lat_q : reg_q;
   end

   // R2: in register mode the output shows the pad of the last active edge
   a_r2_out_reg_path: assert property (@(posedge eff)
      disable iff (mode_i) 1'b1 |=> (cap_o == $past(pad_i)));

   // R4: in latch mode the output tracks the pad up to the closing edge
   a_r4_out_latch_path: assert property (@(negedge eff)
      disable iff (!mode_i) 1'b1 |-> (cap_o == pad_i));
endmodule

// File: tb/inp_capture_cell_tb_top.sv
module inp_capture_cell_tb_top;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic [W-1:0] pad = '0;
   logic         g0 = 1'b0, g1 = 1'b0;
   logic         sel = 1'b0, inv = 1'b0, mode = 1'b0;
   logic [W-1:0] raw, cap;
   int           n_chk = 0, n_bad = 0;
   bit           done = 1'b0;

   always #2.5 clk = ~clk;

   inp_capture_cell #(.WIDTH(W)) dut_i (
      .pad_i(pad), .gclk0_i(g0), .gclk1_i(g1), .clk_sel_i(sel),
      .clk_inv_i(inv), .mode_i(mode), .raw_o(raw), .cap_o(cap)
   );

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s sel=%0b inv=%0b mode=%0b actual=%h expected=%h",
                  req, sel, inv, mode, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   // drive the selected pin so the effective level equals lvl
   task automatic drive_eff(logic lvl);
      step();
      if (sel) g1 = lvl ^ inv; else g0 = lvl ^ inv;
   endtask

   task automatic pulse_other();
      step();
      if (sel) g0 = ~inv; else g1 = ~inv;
      step();
      if (sel) g0 = inv; else g1 = inv;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] held;
      settle();
      check("R6", raw, pad);
      for (int cfg = 0; cfg < 8; cfg++) begin
         step();
         sel = cfg[0]; inv = cfg[1]; mode = cfg[2];
         g0 = inv; g1 = inv;       // effective level low on both pins
         for (int v = 0; v < (1 << W); v++) begin
            step();
            pad = W'(v);
            settle();
            check("R6", raw, W'(v));
            drive_eff(1'b1);      // R3: active phase depends on inv
            settle();
            if (mode) check("R4", cap, W'(v));
            else      check("R2", cap, W'(v));
            step();
            pad = ~W'(v);
            settle();
            check("R6", raw, ~W'(v));
            if (mode) check("R4", cap, ~W'(v));
            else      check("R2", cap, W'(v));
            drive_eff(1'b0);
            step();
            pad = W'(v) ^ W'(5);
            settle();
            held = mode ? ~W'(v) : W'(v);
            if (mode) check("R5", cap, held);
            else      check("R2", cap, held);
            pulse_other();        // R1: deselected pin has no effect
            settle();
            check("R1", cap, held);
            check("R3", cap, held);
         end
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule